// File: doc/BRIEF.md
# Busy-Gated Infrared Receive Byte Buffer

This block holds the bytes that an infrared frame receiver decodes until a CPU collects them. The receiver pushes each decoded byte with a one-cycle strobe. It also drives a busy level that stays high for the whole frame. Up to eight bytes are kept. The CPU takes them oldest first through one read-data port by pulsing a read strobe, and it can watch a live count of the stored bytes.

Reads only remove data while the receiver is idle and the buffer holds something. Any other read returns zero and changes nothing. A byte that arrives while all eight places are occupied is thrown away and sets a sticky overrun flag. The flag stays set until a clear pulse arrives.

Top module: `ir_byte_buffer`

## Requirements
- R1: After reset, `byteCount` is 0, `rdData` is 8'h00 and `overrun` is 0.
- R2: A push (`rxPush` high for one cycle) while `byteCount` is below 8 stores `rxByte`. The count increases by one on the following clock edge.
- R3: A read strobe while `rxBusy` is low and `byteCount` is nonzero loads the oldest stored byte into `rdData` on the next edge. The count drops by one at that edge. Successive reads return the bytes in the order they were pushed.
- R4: A push while `byteCount` equals 8 does not store the byte and leaves the count at 8. `overrun` is high from the next edge onward.
- R5: `overrun` stays high until `ovrClear` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R6: A read strobe while `rxBusy` is high loads 8'h00 into `rdData` and leaves the count unchanged. The next valid read still returns the byte that was oldest before that strobe.
- R7: A read strobe while `byteCount` is 0 loads 8'h00 into `rdData`, and the count stays 0.
- R8: A push and a valid read in the same cycle both take effect. The count is unchanged and the read returns the previous oldest byte.
- R9: `rdData` keeps its value in every cycle without a read strobe.
- R10: Storage indices wrap around. Order is preserved across any number of fill and drain passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rxBusy | input | 1 | High while the receiver is inside a frame |
| rxPush | input | 1 | One-cycle strobe that delivers `rxByte` |
| rxByte | input | 8 | Decoded byte from the receiver |
| rdStrobe | input | 1 | CPU read strobe, one cycle per read |
| ovrClear | input | 1 | Clears the sticky overrun flag |
| rdData | output | 8 | Registered read data |
| byteCount | output | 5 | Number of stored bytes, 0 to 8 |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Every result is registered.

| Stimulus | Result | When it is due |
|---|---|---|
| Push | `byteCount` changes | One edge after the strobe |
| Push at full | `overrun` rises | One edge after the strobe |
| Valid read | `byteCount` drops, `rdData` loads | One edge after the strobe |
| Any read strobe | `rdData` changes | One edge after the strobe |

The bench drives each input just after a falling edge and lets exactly one rising edge pass. It samples at the following falling edge, so each check sees the outcome of one stimulus cycle and nothing else. Expected bytes come from an arithmetic function of the acceptance order, and this function is kept across fill levels 0 to 10. That way, wrap-around of the storage indices is covered by the same checks.

// File: rtl/irbuf_pkg.sv
package irbuf_pkg;
  typedef struct packed {
    logic push;     // store rxByte at write index
    logic pop;      // load oldest byte and advance read index
    logic readReq;  // any read strobe: rdData is updated
  } bufStrobe_t;
endpackage

// File: rtl/irbuf_ctrl.sv
module irbuf_ctrl
  import irbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBusy,
  input  logic             rxPush,
  input  logic             rdStrobe,
  input  logic             ovrClear,
  output bufStrobe_t       strobes,
  output logic [CNT_W-1:0] byteCount,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic isFull, isEmpty, pushOk, popOk, ovrSet;
  logic [CNT_W-1:0] countNext;

  assign isFull  = (byteCount == FULL);
  assign isEmpty = (byteCount == '0);
  assign pushOk  = rxPush && !isFull;
  assign popOk   = rdStrobe && !rxBusy && !isEmpty;
  assign ovrSet  = rxPush && isFull;

  always_comb begin
    strobes.push    = pushOk;
    strobes.pop     = popOk;
    strobes.readReq = rdStrobe;
  end

  always_comb begin
    countNext = byteCount;
    if (pushOk && !popOk) countNext = byteCount + CNT_W'(1);
    else if (popOk && !pushOk) countNext = byteCount - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCount <= '0;
      overrun   <= 1'b0;
    end else begin
      byteCount <= countNext;
      if (ovrSet) overrun <= 1'b1;
      else if (ovrClear) overrun <= 1'b0;
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= FULL);
  // R4
  full_push_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && byteCount == FULL) |=> overrun);
  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ovrClear) |=> overrun);
  // R6
  busy_read_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rxBusy && !rxPush) |=> $stable(byteCount));
endmodule

// File: rtl/irbuf_datapath.sv
module irbuf_datapath
  import irbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobes,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) store[wrPtr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strobes.push) wrPtr <= bump(wrPtr);
      if (strobes.pop)  rdPtr <= bump(rdPtr);
      if (strobes.readReq) rdData <= strobes.pop ? store[rdPtr] : '0;
    end
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.readReq |=> $stable(rdData));
  // R6
  rd_ptr_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pop |=> $stable(rdPtr));
endmodule

// File: rtl/ir_byte_buffer.sv
module ir_byte_buffer
  import irbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxBusy,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rdStrobe,
  input  logic              ovrClear,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  byteCount,
  output logic              overrun
);
  bufStrobe_t strobes;

  irbuf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxBusy(rxBusy), .rxPush(rxPush),
    .rdStrobe(rdStrobe), .ovrClear(ovrClear), .strobes(strobes),
    .byteCount(byteCount), .overrun(overrun)
  );

  irbuf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxByte(rxByte),
    .rdData(rdData)
  );

  // R7
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && byteCount == '0) |=> (rdData == '0));
  // R6
  busy_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rxBusy) |=> (rdData == '0));
endmodule

// File: tb/tb_ir_byte_buffer.sv
module tb_ir_byte_buffer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic rxBusy = 0, rxPush = 0, rdStrobe = 0, ovrClear = 0;
  logic [7:0] rxByte = 0;
  logic [7:0] rdData;
  logic [4:0] byteCount;
  logic overrun;

  int checks = 0, errors = 0;
  int accIdx = 0, readIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_byte_buffer dut (
    .clk(clk), .rstN(rstN), .rxBusy(rxBusy), .rxPush(rxPush), .rxByte(rxByte),
    .rdStrobe(rdStrobe), .ovrClear(ovrClear), .rdData(rdData),
    .byteCount(byteCount), .overrun(overrun)
  );

  function automatic logic [7:0] val(input int k);
    return 8'((k * 29 + 7) & 8'hFF);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one stimulus cycle, then return at the next falling edge
  task automatic step(input logic p, input logic [7:0] b, input logic rd, input logic clr);
    rxPush = p; rxByte = b; rdStrobe = rd; ovrClear = clr;
    @(negedge clk);
    rxPush = 0; rdStrobe = 0; ovrClear = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 count", byteCount, 0);
    chk("R1 data", rdData, 0);
    chk("R1 overrun", overrun, 0);
    rstN = 1;
    @(negedge clk);

    for (int fill = 0; fill <= 10; fill++) begin
      int stored;
      step(0, 0, 0, 1);
      chk("R5 cleared", overrun, 0);
      rxBusy = 1;
      for (int k = 0; k < fill; k++) begin
        if (k < 8) begin
          step(1, val(accIdx), 0, 0);
          accIdx++;
          chk("R2 count", byteCount, k + 1);
        end else begin
          step(1, 8'hEE, 0, 0);
          chk("R4 count", byteCount, 8);
        end
        chk("R4 overrun", overrun, (k >= 8) ? 1 : 0);
      end
      stored = (fill > 8) ? 8 : fill;
      step(0, 0, 1, 0);
      chk("R6 data", rdData, 0);
      chk("R6 count", byteCount, stored);
      rxBusy = 0;
      for (int j = 0; j <= stored; j++) begin
        step(0, 0, 1, 0);
        if (j < stored) begin
          chk("R3 R10 data", rdData, val(readIdx));
          readIdx++;
          chk("R3 count", byteCount, stored - j - 1);
          step(0, 0, 0, 0);
          chk("R9 hold", rdData, val(readIdx - 1));
        end else begin
          chk("R7 data", rdData, 0);
          chk("R7 count", byteCount, 0);
        end
      end
      chk("R5 sticky", overrun, (fill > 8) ? 1 : 0);
    end

    // R8: push and valid read together with busy low
    step(1, val(accIdx), 0, 0); accIdx++;
    step(1, val(accIdx), 0, 0); accIdx++;
    step(1, val(accIdx), 1, 0); accIdx++;
    chk("R8 data", rdData, val(readIdx)); readIdx++;
    chk("R8 count", byteCount, 2);
    step(0, 0, 1, 0);
    chk("R8 order", rdData, val(readIdx)); readIdx++;
    step(0, 0, 1, 0);
    chk("R8 order2", rdData, val(readIdx)); readIdx++;
    chk("R8 empty", byteCount, 0);

    // R5: set and clear in the same cycle, set wins
    rxBusy = 1;
    for (int k = 0; k < 8; k++) begin
      step(1, val(accIdx), 0, 0); accIdx++;
    end
    step(1, 8'h55, 0, 1);
    chk("R5 set wins", overrun, 1);
    step(0, 0, 0, 1);
    chk("R5 clear", overrun, 0);
    rxBusy = 0;
    for (int k = 0; k < 8; k++) begin
      step(0, 0, 1, 0);
      chk("R10 drain", rdData, val(readIdx)); readIdx++;
    end
    chk("R10 empty", byteCount, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule